// File: doc/BRIEF.md
# Two-Wire Serial Memory Page Write Slave

This block is the write side of a two-wire serial memory device. A fast system clock samples the bus clock and data lines. The block finds Start and Stop conditions and accepts a device select byte that carries the fixed select code with the direction bit cleared. It then takes a two-byte address, most significant byte first, and gathers the following data bytes into a page buffer. Each accepted byte is acknowledged by pulling the data line low through an open-drain enable.

A Stop placed directly after an acknowledge commits the buffered bytes. The block then goes busy for a fixed number of system clocks and writes the bytes out one per clock on a simple synchronous write port. While busy it does not drive the bus and does not react to it. A write-control input seen high at any point between Start and the end of the second address byte keeps the transaction out of the top quarter of the array.

Top module: `eepromPageWriter`

## Requirements
- R1: During and after reset, with no bus activity, `sdaOutEn`, `busy` and `memWe` are all 0.
- R2: A select byte is acknowledged only when its upper seven bits equal `DEV_CODE` (default 1010000) and its bit 0 (direction) is 0. A select byte that fails this gets no acknowledge, and the block ignores the bus until the next Start.
- R3: After an accepted select byte, the block acknowledges both address bytes and every data byte. The acknowledge holds the data line low for the whole ninth clock of the byte. The address is formed with the first address byte as bits 15..8 and the second as bits 7..0. Address bits at and above log2(`MEM_DEPTH`) are ignored.
- R4: If write control is high at any sampled instant from Start until the end of the second address byte, no location whose two most significant used address bits are 11 is written. Write control that is high only during the data bytes has no effect.
- R5: A write cycle starts only on a Stop that comes right after the acknowledge of a data byte. A Stop inside a byte, or a Stop right after the address bytes, ends the transaction with no memory write and no busy period.
- R6: A committed write holds `busy` high for exactly `WR_CYCLES` clocks. `memWe` is high only while `busy` is high. Each buffered location is written exactly once, with its byte.
- R7: While `busy` is high, `sdaOutEn` stays 0. A Start or select byte arriving in that time is not acknowledged and causes no write.
- R8: Data bytes go to successive locations starting at the given address. Only the low log2(`PAGE_BYTES`) address bits advance, and they wrap within the page. When a page wraps, a later byte to the same location replaces the earlier one.
- R9: A Start in the middle of a transaction discards everything buffered so far and begins a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired level) |
| wpIn | input | 1 | Write control; high requests protection of the top quarter |
| sdaOutEn | output | 1 | Open-drain enable; 1 pulls the data line low |
| busy | output | 1 | High during the internal write cycle |
| memWe | output | 1 | Memory write enable, one byte per clock |
| memAddr | output | log2(MEM_DEPTH) | Memory byte address |
| memData | output | 8 | Memory write data |

## Verification
The hardest state to reach from the ports is a bus transaction that overlaps the internal write cycle. The bench makes one by issuing a Start and a full select byte right after a committing Stop. It then checks that no acknowledge appears and that memory does not change once busy falls. Write-control protection depends on when the pin is high, not only on whether it is high. The stimulus therefore raises it in three separate windows: across the whole address phase, for only the first address byte, and for only the data phase. Random transactions bias addresses toward the top quarter, and their lengths exceed the page size so that the buffer wraps.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_BUSY
  } busState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       clearBuf;
    logic       loadHi;
    logic       loadLo;
    logic       pushData;
    logic       commit;
    logic       protect;
    logic [7:0] rxByte;
  } dpStrobe_t;

endpackage

// File: rtl/eewrSync.sv
module eewrSync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '1;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/eewrCtrl.sv
module eewrCtrl
  import eewr_pkg::*;
#(
  parameter logic [6:0] DEV_CODE  = 7'h50,
  parameter int         WR_CYCLES = 2000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      wpIn,
  output logic      sdaOutEn,
  output logic      busy,
  output dpStrobe_t strb
);

  localparam int CW = $clog2(WR_CYCLES + 1);

  logic [2:0] syncOut;
  logic sclS, sdaS, wpS;
  logic sclP, sdaP;

  eewrSync #(.W(3), .STAGES(2)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din ({wpIn, sdaIn, sclIn}),
    .dout(syncOut)
  );

  assign sclS = syncOut[0];
  assign sdaS = syncOut[1];
  assign wpS  = syncOut[2];

  busState_t     state;
  logic [3:0]    bitCnt;
  logic [7:0]    shiftR;
  logic          ackOn;
  logic          gotData;
  logic          wpLatch;
  logic [CW-1:0] cycCnt;

  logic startDet, stopDet, riseDet, fallDet;
  logic active, byteEnd, selOk, commitOk, addrPhase;

  assign startDet  = sclS & sclP & sdaP & ~sdaS;
  assign stopDet   = sclS & sclP & ~sdaP & sdaS;
  assign riseDet   = sclS & ~sclP;
  assign fallDet   = ~sclS & sclP;
  assign active    = state inside {ST_SEL, ST_AHI, ST_ALO, ST_DATA};
  assign addrPhase = state inside {ST_SEL, ST_AHI, ST_ALO};
  assign byteEnd   = active & fallDet & (bitCnt == 4'd8) & ~ackOn;
  assign selOk     = (shiftR == {DEV_CODE, 1'b0});
  assign commitOk  = stopDet & (state == ST_DATA) & gotData & (bitCnt == 4'd1);

  always_comb begin
    strb          = '0;
    strb.rxByte   = shiftR;
    strb.protect  = wpLatch;
    strb.clearBuf = startDet & (state != ST_BUSY);
    strb.loadHi   = byteEnd & (state == ST_AHI);
    strb.loadLo   = byteEnd & (state == ST_ALO);
    strb.pushData = byteEnd & (state == ST_DATA);
    strb.commit   = commitOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
      state   <= ST_IDLE;
      bitCnt  <= '0;
      shiftR  <= '0;
      ackOn   <= 1'b0;
      gotData <= 1'b0;
      wpLatch <= 1'b0;
      cycCnt  <= '0;
    end else begin
      sclP <= sclS;
      sdaP <= sdaS;
      if (state == ST_BUSY) begin
        cycCnt <= cycCnt + 1'b1;
        if (cycCnt == CW'(WR_CYCLES - 1)) state <= ST_IDLE;
      end else if (startDet) begin
        state   <= ST_SEL;
        bitCnt  <= '0;
        ackOn   <= 1'b0;
        gotData <= 1'b0;
        wpLatch <= wpS;
      end else if (stopDet) begin
        ackOn  <= 1'b0;
        bitCnt <= '0;
        cycCnt <= '0;
        state  <= commitOk ? ST_BUSY : ST_IDLE;
      end else if (active) begin
        if (addrPhase) wpLatch <= wpLatch | wpS;
        if (riseDet) begin
          if (bitCnt < 4'd8) begin
            shiftR <= {shiftR[6:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (bitCnt == 4'd8) begin
            bitCnt <= 4'd9;
          end
        end
        if (fallDet) begin
          if (byteEnd) begin
            if (state != ST_SEL || selOk) begin
              ackOn <= 1'b1;
              if (state == ST_DATA) gotData <= 1'b1;
            end else begin
              state  <= ST_IDLE;
              bitCnt <= '0;
            end
          end else if (bitCnt == 4'd9) begin
            ackOn  <= 1'b0;
            bitCnt <= '0;
            unique case (state)
              ST_SEL:  state <= ST_AHI;
              ST_AHI:  state <= ST_ALO;
              default: state <= ST_DATA;
            endcase
          end
        end
      end
    end
  end

  assign busy     = (state == ST_BUSY);
  assign sdaOutEn = ackOn & ~busy;

endmodule

// File: rtl/eewrDatapath.sv
module eewrDatapath
  import eewr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam int PN_W = ADDR_W - PG_W;

  logic [7:0]      addrHi;
  logic [15:0]     fullAddr;
  logic [PN_W-1:0] pageReg;
  logic [PG_W-1:0] ptr;
  logic            stepOn;
  logic [PG_W-1:0] idx;
  logic            protReg;
  logic            topQ;

  logic [7:0] bufArr [PAGE_BYTES];
  logic       vldArr [PAGE_BYTES];

  assign fullAddr = {addrHi, strb.rxByte};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrHi  <= '0;
      pageReg <= '0;
      ptr     <= '0;
    end else begin
      if (strb.loadHi) addrHi <= strb.rxByte;
      if (strb.loadLo) begin
        pageReg <= PN_W'(fullAddr >> PG_W);
        ptr     <= PG_W'(fullAddr);
      end else if (strb.pushData) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_entry
    logic [7:0] ent;
    logic       vld;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ent <= '0;
        vld <= 1'b0;
      end else if (strb.clearBuf) begin
        vld <= 1'b0;
      end else if (strb.pushData && ptr == PG_W'(i)) begin
        ent <= strb.rxByte;
        vld <= 1'b1;
      end
    end
    assign bufArr[i] = ent;
    assign vldArr[i] = vld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepOn  <= 1'b0;
      idx     <= '0;
      protReg <= 1'b0;
    end else if (strb.commit) begin
      stepOn  <= 1'b1;
      idx     <= '0;
      protReg <= strb.protect;
    end else if (stepOn) begin
      idx <= idx + 1'b1;
      if (idx == PG_W'(PAGE_BYTES - 1)) stepOn <= 1'b0;
    end
  end

  assign topQ    = (pageReg[PN_W-1 -: 2] == 2'b11);
  assign memWe   = stepOn & vldArr[idx] & ~(protReg & topQ);
  assign memAddr = {pageReg, idx};
  assign memData = bufArr[idx];

endmodule

// File: rtl/eepromPageWriter.sv
module eepromPageWriter
  import eewr_pkg::*;
#(
  parameter logic [6:0] DEV_CODE   = 7'h50,
  parameter int         MEM_DEPTH  = 8192,
  parameter int         PAGE_BYTES = 32,
  parameter int         WR_CYCLES  = 2000,
  localparam int        ADDR_W     = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              wpIn,
  output logic              sdaOutEn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData
);

  dpStrobe_t strb;

  eewrCtrl #(.DEV_CODE(DEV_CODE), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .wpIn    (wpIn),
    .sdaOutEn(sdaOutEn),
    .busy    (busy),
    .strb    (strb)
  );

  eewrDatapath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .memWe  (memWe),
    .memAddr(memAddr),
    .memData(memData)
  );

endmodule

// File: rtl/eewrChecker.sv
module eewrChecker #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              sdaOutEn,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              commitStb,
  input logic              protectStb
);

  localparam int PG_W = $clog2(PAGE_BYTES);

  logic protSeen;

  always_ff @(posedge clk) begin
    if (!rstN) protSeen <= 1'b0;
    else if (commitStb) protSeen <= protectStb;
  end

  a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOutEn);

  a_r6_we_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  a_r4_top_guarded: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && protSeen) |-> (memAddr[ADDR_W-1 -: 2] != 2'b11));

  a_r8_page_steady: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> $stable(memAddr[ADDR_W-1:PG_W]));

  a_r5_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commitStb));

endmodule

bind eepromPageWriter eewrChecker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .sdaOutEn  (sdaOutEn),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .commitStb (strb.commit),
  .protectStb(strb.protect)
);

// File: tb/eepromPageWriter_bench.sv
module eepromPageWriter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 4;
  localparam int DEPTH      = 1024;
  localparam int PB         = 8;
  localparam int WRC        = 300;
  localparam int AW         = 10;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1, wpPin = 1'b0;
  logic sdaOutEn, busy, memWe;
  logic [AW-1:0] memAddr;
  logic [7:0] memData;
  wire sdaLine = mSda & ~sdaOutEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  eepromPageWriter #(.DEV_CODE(DEV), .MEM_DEPTH(DEPTH), .PAGE_BYTES(PB), .WR_CYCLES(WRC))
    u_eepromPageWriter (
      .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .wpIn(wpPin),
      .sdaOutEn(sdaOutEn), .busy(busy), .memWe(memWe), .memAddr(memAddr), .memData(memData));

  logic [7:0] expMem [DEPTH];
  logic [7:0] gotMem [DEPTH];
  logic [7:0] txData [16];
  int nChecks = 0, nBad = 0;
  int busySeen = 0;
  bit overlapSeen = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) gotMem[i] <= 8'h00;
    end else if (memWe) begin
      gotMem[memAddr] <= memData;
    end
  end

  always @(negedge clk) begin
    if (busy) busySeen++;
    if (busy && sdaOutEn) overlapSeen = 1;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit isTop(input int a);
    return ((a >> (AW - 2)) & 3) == 3;
  endfunction

  function automatic int slotAddr(input int base, input int i);
    int pageStart = base - (base % PB);
    return pageStart + ((base % PB + i) % PB);
  endfunction

  task automatic startCond();
    mSda = 1; tick(Q); mScl = 1; tick(Q); mSda = 0; tick(Q); mScl = 0; tick(Q);
  endtask

  task automatic stopCond();
    mSda = 0; tick(Q); mScl = 1; tick(Q); mSda = 1; tick(Q);
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; tick(Q); mScl = 1; tick(2*Q); mScl = 0; tick(Q);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    mSda = 1; tick(Q); mScl = 1; tick(Q);
    acked = (sdaLine == 1'b0);
    tick(Q); mScl = 0; tick(Q);
  endtask

  task automatic cmpMem(input string req);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++)
      if (bad < 0 && gotMem[i] !== expMem[i]) bad = i;
    if (bad < 0) check(1, req, "memory", 0, 0);
    else check(0, req, $sformatf("memory at %0d", bad), int'(gotMem[bad]), int'(expMem[bad]));
  endtask

  task automatic waitQuiet();
    int guard = 0;
    tick(8);
    while (busy && guard < 5000) begin tick(1); guard++; end
    tick(4);
  endtask

  // wpMode: 0 never, 1 whole address phase, 2 data phase only, 3 first address byte only
  // endMode: 0 proper stop, 1 stop inside a byte, 2 stop right after address
  task automatic doTxn(input int addr16, input int n, input int wpMode, input int endMode,
                       input bit intrude, input bit withStart);
    bit a;
    bit commit;
    bit prot;
    int base;
    busySeen = 0;
    overlapSeen = 0;
    if (wpMode == 1) wpPin = 1;
    if (withStart) startCond();
    sendByte({DEV, 1'b0}, a);
    check(a, "R2", "select ack", a, 1);
    if (wpMode == 3) wpPin = 1;
    sendByte(addr16[15:8], a);
    check(a, "R3", "addr hi ack", a, 1);
    if (wpMode == 3) wpPin = 0;
    sendByte(addr16[7:0], a);
    check(a, "R3", "addr lo ack", a, 1);
    if (wpMode == 1) wpPin = 0;
    if (endMode != 2) begin
      if (wpMode == 2) wpPin = 1;
      for (int i = 0; i < n; i++) begin
        sendByte(txData[i], a);
        check(a, "R3", "data ack", a, 1);
      end
      wpPin = 0;
      if (endMode == 1) sendBits(8'hA5, 3);
    end
    stopCond();
    commit = (endMode == 0) && (n > 0);
    if (intrude) begin
      startCond();
      sendByte({DEV, 1'b0}, a);
      check(!a, "R7", "select ack while busy", a, 0);
      stopCond();
    end
    if (commit) begin
      prot = (wpMode == 1) || (wpMode == 3);
      base = addr16 % DEPTH;
      for (int i = 0; i < n; i++) begin
        int sa = slotAddr(base, i);
        if (!(prot && isTop(sa))) expMem[sa] = txData[i];
      end
    end
    waitQuiet();
    check(busySeen == (commit ? WRC : 0), commit ? "R6" : "R5", "busy cycles",
          busySeen, commit ? WRC : 0);
    check(!overlapSeen, "R7", "ack during busy", overlapSeen, 0);
    cmpMem(commit ? "R8" : "R5");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nBad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    bit a;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) expMem[i] = 8'h00;
    tick(5);
    check(sdaOutEn == 0 && busy == 0 && memWe == 0, "R1", "outputs in reset",
          {sdaOutEn, busy, memWe}, 0);
    rstN = 1;
    tick(10);
    check(sdaOutEn == 0 && busy == 0 && memWe == 0, "R1", "outputs after reset",
          {sdaOutEn, busy, memWe}, 0);

    // single byte write
    txData[0] = 8'h3C;
    doTxn(16'h0005, 1, 0, 0, 0, 1);

    // page wrap with overwrite: start at slot 6, ten bytes in an eight byte page
    for (int i = 0; i < 10; i++) txData[i] = 8'h80 + 8'(i);
    doTxn(16'h0016, 10, 0, 0, 0, 1);

    // bad select bytes
    busySeen = 0;
    startCond();
    sendByte({DEV, 1'b1}, a);
    check(!a, "R2", "read select ack", a, 0);
    sendByte(8'h00, a);
    check(!a, "R2", "byte after rejected select", a, 0);
    stopCond();
    startCond();
    sendByte({DEV ^ 7'h01, 1'b0}, a);
    check(!a, "R2", "wrong code ack", a, 0);
    stopCond();
    waitQuiet();
    check(busySeen == 0, "R2", "busy after rejected select", busySeen, 0);
    cmpMem("R2");

    // stops in the wrong slot
    txData[0] = 8'h11; txData[1] = 8'h22;
    doTxn(16'h0040, 2, 0, 2, 0, 1);
    doTxn(16'h0040, 2, 0, 1, 0, 1);

    // write control windows on the top quarter
    for (int i = 0; i < 4; i++) txData[i] = 8'hC0 + 8'(i);
    doTxn(16'h0300, 4, 1, 0, 0, 1);
    doTxn(16'h0308, 4, 3, 0, 0, 1);
    doTxn(16'h0310, 4, 2, 0, 0, 1);
    doTxn(16'h0100, 4, 1, 0, 0, 1);
    // address bits above the array width ignored
    doTxn(16'hFF25, 3, 0, 0, 0, 1);

    // bus traffic during the write cycle
    txData[0] = 8'h5A;
    doTxn(16'h0077, 1, 0, 0, 1, 1);

    // repeated start discards the first transaction (R9)
    startCond();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'h60, a);
    sendByte(8'hEE, a);
    sendByte(8'hDD, a);
    txData[0] = 8'h42;
    doTxn(16'h0068, 1, 0, 0, 0, 1);
    check(gotMem[16'h60] == 8'h00 && gotMem[16'h61] == 8'h00, "R9", "discarded bytes",
          int'(gotMem[16'h60]), 0);

    // constrained random transactions
    for (int k = 0; k < 25; k++) begin
      int addr = int'($urandom & 32'hFFFF);
      int n = 1 + int'($urandom % 12);
      int wm = int'($urandom % 4);
      int em = ($urandom % 6 == 0) ? 1 + int'($urandom % 2) : 0;
      if ($urandom % 2 == 1) addr = addr | 16'h0300;
      for (int i = 0; i < n; i++) txData[i] = 8'($urandom);
      doTxn(addr, n, wm, em, 0, 1);
    end

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule